// File: doc/BRIEF.md
# Page-Fault Bus Ownership Controller

This block decides which of two masters drives a shared memory bus. The main master runs ordinary programs and holds the bus by default. A second, helper master exists only to service page swaps. When the memory translation logic raises a page fault, the controller stalls the main master. It waits for the main master's current bus cycle to finish and then hands the bus to the helper.

When the helper reports that the swap is complete, the controller waits for the helper's own bus cycle to finish. It then gives the bus back to the main master and pulses a retry indication, so that the faulting access runs again. The controller never arbitrates between ordinary requests. Ownership moves only on a fault and comes back only after a completed swap.

A request input from each master means that the master has a bus cycle in progress, or is asking for one. A grant is withdrawn only while the matching request is low, so the two masters never drive the bus in the same cycle.

Top module: `fault_bus_handoff`

## Requirements
- R1: After reset, main_gnt_o is 1, and helper_gnt_o, main_halt_o and main_retry_o are 0.
- R2: main_gnt_o and helper_gnt_o are never 1 in the same cycle.
- R3: fault_i sampled high while the main master owns the bus raises main_halt_o in the next cycle. main_gnt_o stays high until a clock edge at which main_req_i is 0 and helper_req_i is 1. After that edge, main_gnt_o is 0 and helper_gnt_o is 1.
- R4: main_halt_o stays 1 from the cycle after a fault is accepted until the cycle in which main_gnt_o returns to 1.
- R5: A swap_done_i pulse sampled while the helper holds the grant starts the return. helper_gnt_o stays 1 until an edge at which helper_req_i is 0. After that edge, main_gnt_o is 1 and helper_gnt_o is 0.
- R6: main_retry_o is 1 for exactly the first cycle in which the main master holds the bus again after a swap, and is 0 at all other times.
- R7: fault_i has no effect while the helper holds the grant. This includes the cycle in which swap_done_i is high and the return phase.
- R8: swap_done_i has no effect unless the helper holds the grant and no return is already under way.
- R9: A fault sampled in the same cycle that main_retry_o is high is accepted and starts a new handoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Page fault raised by the translation logic |
| main_req_i | input | 1 | Main master has a bus cycle in progress |
| main_gnt_o | output | 1 | Main master owns the bus |
| helper_req_i | input | 1 | Helper master requests, or is running, a bus cycle |
| helper_gnt_o | output | 1 | Helper master owns the bus |
| swap_done_i | input | 1 | One-cycle pulse from the helper when the swap is complete |
| main_halt_o | output | 1 | Stalls the main master |
| main_retry_o | output | 1 | One-cycle pulse telling the main master to rerun the faulted access |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives both. First, a fault can arrive in the very edge where the helper signals completion. The bench raises fault_i together with swap_done_i and expects the return to go on normally. Second, a new fault can arrive in the one cycle in which the retry pulse is high. The bench expects that fault to take effect, so that the main master is halted again in the following cycle.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_FAULT  = 2'd1,
        HS_HELPER = 2'd2,
        HS_RETURN = 2'd3
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
        logic      retry;
    } hs_regs_t;

endpackage

// File: rtl/handoff_seq.sv
module handoff_seq
    import handoff_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fault_i,
    input  logic      main_req_i,
    input  logic      helper_req_i,
    input  logic      swap_done_i,
    output hs_state_e state_o,
    output logic      retry_o
);

    hs_regs_t regs_d;
    hs_regs_t regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.retry = 1'b0;
        unique case (regs_q.state)
            HS_IDLE: begin
                if (fault_i) regs_d.state = HS_FAULT;
            end
            HS_FAULT: begin
                if (!main_req_i && helper_req_i) regs_d.state = HS_HELPER;
            end
            HS_HELPER: begin
                if (swap_done_i) regs_d.state = HS_RETURN;
            end
            HS_RETURN: begin
                if (!helper_req_i) begin
                    regs_d.state = HS_IDLE;
                    regs_d.retry = 1'b1;
                end
            end
            default: regs_d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state <= HS_IDLE;
            regs_q.retry <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign retry_o = regs_q.retry;

    // R7: a fault never moves the sequencer out of the helper phase
    p_fault_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == HS_HELPER && !swap_done_i) |=> (regs_q.state == HS_HELPER));

    // R8: a completion pulse outside the helper phase leaves the sequencer alone
    p_done_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == HS_IDLE && swap_done_i && !fault_i) |=> (regs_q.state == HS_IDLE));

endmodule

// File: rtl/handoff_decode.sv
module handoff_decode
    import handoff_pkg::*;
(
    input  hs_state_e state_i,
    output logic      main_gnt_o,
    output logic      helper_gnt_o,
    output logic      halt_o
);

    always_comb begin
        main_gnt_o   = 1'b0;
        helper_gnt_o = 1'b0;
        halt_o       = 1'b1;
        unique case (state_i)
            HS_IDLE: begin
                main_gnt_o = 1'b1;
                halt_o     = 1'b0;
            end
            HS_FAULT:  main_gnt_o   = 1'b1;
            HS_HELPER: helper_gnt_o = 1'b1;
            HS_RETURN: helper_gnt_o = 1'b1;
            default:   halt_o       = 1'b1;
        endcase
    end

endmodule

// File: rtl/fault_bus_handoff.sv
module fault_bus_handoff
    import handoff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic main_req_i,
    output logic main_gnt_o,
    input  logic helper_req_i,
    output logic helper_gnt_o,
    input  logic swap_done_i,
    output logic main_halt_o,
    output logic main_retry_o
);

    hs_state_e seq_state;

    handoff_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_i      (fault_i),
        .main_req_i   (main_req_i),
        .helper_req_i (helper_req_i),
        .swap_done_i  (swap_done_i),
        .state_o      (seq_state),
        .retry_o      (main_retry_o)
    );

    handoff_decode u_dec (
        .state_i      (seq_state),
        .main_gnt_o   (main_gnt_o),
        .helper_gnt_o (helper_gnt_o),
        .halt_o       (main_halt_o)
    );

    // R2: one owner at most
    p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_gnt_o && helper_gnt_o));

    // R3: the main grant is never withdrawn while its cycle was still running
    p_main_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_gnt_o && main_req_i) |=> main_gnt_o);

    // R5: the helper grant is never withdrawn while its cycle was still running
    p_helper_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (helper_gnt_o && helper_req_i) |=> helper_gnt_o);

    // R4: the main master is stalled whenever the helper owns the bus
    p_halt_helper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        helper_gnt_o |-> main_halt_o);

    // R6: retry lasts one cycle and comes with the main grant
    p_retry_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        main_retry_o |-> (main_gnt_o && !main_halt_o) ##1 !main_retry_o);

endmodule

// File: tb/fault_bus_handoff_test.sv
`timescale 1ns/1ps
module fault_bus_handoff_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_i = 1'b0;
    logic main_req_i = 1'b0;
    logic helper_req_i = 1'b0;
    logic swap_done_i = 1'b0;
    logic main_gnt_o, helper_gnt_o, main_halt_o, main_retry_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fault_bus_handoff uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_i      (fault_i),
        .main_req_i   (main_req_i),
        .main_gnt_o   (main_gnt_o),
        .helper_req_i (helper_req_i),
        .helper_gnt_o (helper_gnt_o),
        .swap_done_i  (swap_done_i),
        .main_halt_o  (main_halt_o),
        .main_retry_o (main_retry_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // outputs in order: main_gnt, helper_gnt, halt, retry
    task automatic chk_all(input string req, input logic [3:0] exp);
        chk(req, "main_gnt", main_gnt_o, exp[3]);
        chk(req, "helper_gnt", helper_gnt_o, exp[2]);
        chk(req, "halt", main_halt_o, exp[1]);
        chk(req, "retry", main_retry_o, exp[0]);
        chk("R2", "exclusive", main_gnt_o & helper_gnt_o, 1'b0);
    endtask

    // Drive into helper ownership from idle; main cycle ends after busy_cycles
    task automatic enter_helper(input int busy_cycles);
        fault_i = 1'b1; main_req_i = 1'b1; helper_req_i = 1'b1;
        step();
        fault_i = 1'b0;
        chk_all("R3", 4'b1010);
        for (int i = 0; i < busy_cycles; i++) begin
            step();
            chk_all("R4", 4'b1010);
        end
        main_req_i = 1'b0;
        step();
        chk_all("R3", 4'b0110);
    endtask

    task automatic t_reset();
        chk_all("R1", 4'b1000);
    endtask

    task automatic t_basic_swap();
        enter_helper(2);
        step();
        chk_all("R4", 4'b0110);
        swap_done_i = 1'b1;
        step();
        swap_done_i = 1'b0;
        chk_all("R5", 4'b0110);
        step();
        chk_all("R5", 4'b0110);
        helper_req_i = 1'b0;
        step();
        chk_all("R6", 4'b1001);
        step();
        chk_all("R6", 4'b1000);
    endtask

    task automatic t_fault_in_helper();
        enter_helper(0);
        fault_i = 1'b1;
        step();
        chk_all("R7", 4'b0110);
        swap_done_i = 1'b1;
        step();
        swap_done_i = 1'b0;
        chk_all("R7", 4'b0110);
        helper_req_i = 1'b0;
        step();
        fault_i = 1'b0;
        chk_all("R7", 4'b1001);
        step();
        chk_all("R7", 4'b1000);
    endtask

    task automatic t_stray_done();
        swap_done_i = 1'b1;
        step();
        swap_done_i = 1'b0;
        chk_all("R8", 4'b1000);
        fault_i = 1'b1; main_req_i = 1'b1; helper_req_i = 1'b1;
        step();
        fault_i = 1'b0;
        swap_done_i = 1'b1;
        step();
        swap_done_i = 1'b0;
        chk_all("R8", 4'b1010);
        main_req_i = 1'b0;
        step();
        chk_all("R8", 4'b0110);
        step();
        chk_all("R8", 4'b0110);
        swap_done_i = 1'b1;
        step();
        swap_done_i = 1'b0;
        helper_req_i = 1'b0;
        step();
        chk_all("R6", 4'b1001);
    endtask

    task automatic t_fault_on_retry();
        enter_helper(1);
        swap_done_i = 1'b1;
        helper_req_i = 1'b0;
        step();
        swap_done_i = 1'b0;
        chk_all("R5", 4'b0110);
        step();
        chk_all("R9", 4'b1001);
        fault_i = 1'b1; main_req_i = 1'b0; helper_req_i = 1'b0;
        step();
        fault_i = 1'b0;
        chk_all("R9", 4'b1010);
        step();
        chk_all("R3", 4'b1010);
        helper_req_i = 1'b1;
        step();
        chk_all("R9", 4'b0110);
        swap_done_i = 1'b1; helper_req_i = 1'b0;
        step();
        swap_done_i = 1'b0;
        step();
        chk_all("R6", 4'b1001);
        step();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic_swap();
        t_fault_in_helper();
        t_stray_done();
        t_fault_on_retry();
        finished = 1'b1;
        report();
    end

    initial begin
        #50000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

endmodule